// File: doc/BRIEF.md
# Programmable Preamble Generator

This block puts a preamble on the transmit serial line ahead of every burst. The preamble has two parts. First comes a short sync pattern, sent as many times as configuration asks. Then a longer frame delimiter follows once. Both parts have a programmable length and bit pattern. The preamble bits go straight to the line: the block adds no checksum and inserts no stuffing bits.

A single `start` strobe launches a preamble. After that, every cycle in which `bit_en` is high moves the output forward by one bit, so the bit rate is set entirely by how often the enable occurs. While a bit is on the line, `ser_vld` is high. After the last delimiter bit, `done` is raised for exactly one bit period so that the user-data path can take over the line. The configuration inputs must only be changed while no preamble is in progress.

Top module: `preamble_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) returns the block to idle. In the following cycle `ser_vld`, `done` and `ser_bit` are all 0.
- R2: A sync word is the low L bits of `sync_pat`, where L = `sync_len_code`+1 for codes 1 to 7. Its bits are sent from bit L-1 down to bit 0.
- R3: The sync word is sent exactly `sync_reps` times, for any value from 0 to 255. When the count is 0, no sync bits are sent.
- R4: After the last sync word, the delimiter is sent once. It is the low M bits of `delim_pat`, where M = `delim_len_code`+1 for codes 1 to 31, and its bits go from bit M-1 down to bit 0.
- R5: A length code of 0, on either field, is treated as a length of 2 bits.
- R6: The output moves forward only on cycles where `bit_en` is high. While `bit_en` is low, `ser_bit` and `ser_vld` keep their values.
- R7: The `bit_en` that consumes the last delimiter bit raises `done`. `done` stays high until the next `bit_en` and then falls, so it lasts one bit period. `ser_vld` is low while `done` is high, and the block is idle afterwards.
- R8: A `start` pulse is ignored while a preamble or its done period is in progress. The preamble in flight finishes unchanged.
- R9: A `start` pulse in idle makes the first preamble bit visible, with `ser_vld` high, in the cycle after the start edge.
- R10: A reset in the middle of a preamble aborts it. The block then stays idle, even with `bit_en` toggling, until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch a preamble (acted on only when idle) |
| bit_en | input | 1 | Bit-rate enable; one bit is consumed per high cycle |
| sync_pat | input | 8 | Sync word pattern |
| sync_len_code | input | 3 | Sync word length code (length = code+1, code 0 gives 2) |
| sync_reps | input | 8 | Number of sync words to send (0 to 255) |
| delim_pat | input | 32 | Frame delimiter pattern |
| delim_len_code | input | 5 | Delimiter length code (length = code+1, code 0 gives 2) |
| ser_bit | output | 1 | Serial preamble bit |
| ser_vld | output | 1 | High while `ser_bit` carries a preamble bit |
| done | output | 1 | One bit period after the last delimiter bit |

## Verification
The assertions that bound the bit index by the decoded field length, and the repeat counter by the programmed count, assume that the configuration inputs stay fixed from the `start` pulse until `done` falls. The assertion that the output holds while `bit_en` is low rests on the same assumption. The stimulus therefore writes a new configuration only at the negative edge, while the block is idle, and holds it for the whole frame. The `start` and `bit_en` inputs are free to take any pattern. The bench uses this freedom: it sends enables with gaps of one, two and three cycles, holds the enable low for a long stretch, and pulses `start` in the middle of a frame.

// File: rtl/pre_pkg.sv
package pre_pkg;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_SYNC  = 2'd1,
        PS_DELIM = 2'd2,
        PS_FIN   = 2'd3
    } pre_state_e;

endpackage

// File: rtl/pre_len_dec.sv
// Turns a field length code into the index of the first (highest) bit to send.
// Length is code+1; code 0 is promoted to the 2-bit minimum.
module pre_len_dec #(
    parameter int CW = 3
) (
    input  logic [CW-1:0] code,
    output logic [CW-1:0] top_idx
);
    always_comb begin
        if (code == '0) begin
            top_idx = CW'(1);
        end else begin
            top_idx = code;
        end
    end

    always_comb begin
        assert_top_nonzero_R5: assert (top_idx != '0);
    end
endmodule

// File: rtl/pre_bit_sel.sv
// Picks one bit of a pattern by index, built as a one-hot AND/OR tree.
module pre_bit_sel #(
    parameter int W = 8,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  pat,
    input  logic [IW-1:0] idx,
    output logic          bit_o
);
    logic [W-1:0] hit;

    for (genvar i = 0; i < W; i++) begin : g_hit
        assign hit[i] = pat[i] & (idx == IW'(i));
    end

    assign bit_o = |hit;
endmodule

// File: rtl/preamble_gen.sv
module preamble_gen #(
    parameter int SYNC_W  = 8,
    parameter int DELIM_W = 32,
    parameter int REP_W   = 8,
    localparam int SCW    = $clog2(SYNC_W),
    localparam int DCW    = $clog2(DELIM_W),
    localparam int IDX_W  = (DCW > SCW) ? DCW : SCW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               bit_en,
    input  logic [SYNC_W-1:0]  sync_pat,
    input  logic [SCW-1:0]     sync_len_code,
    input  logic [REP_W-1:0]   sync_reps,
    input  logic [DELIM_W-1:0] delim_pat,
    input  logic [DCW-1:0]     delim_len_code,
    output logic               ser_bit,
    output logic               ser_vld,
    output logic               done
);
    import pre_pkg::*;

    typedef struct packed {
        pre_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [REP_W-1:0] rep;
    } regs_t;

    regs_t r_d, r_q;

    logic [SCW-1:0] sync_top;
    logic [DCW-1:0] delim_top;
    logic           sync_bit, delim_bit;

    pre_len_dec #(.CW(SCW)) u_sync_len (
        .code    (sync_len_code),
        .top_idx (sync_top)
    );

    pre_len_dec #(.CW(DCW)) u_delim_len (
        .code    (delim_len_code),
        .top_idx (delim_top)
    );

    pre_bit_sel #(.W(SYNC_W)) u_sync_sel (
        .pat   (sync_pat),
        .idx   (r_q.idx[SCW-1:0]),
        .bit_o (sync_bit)
    );

    pre_bit_sel #(.W(DELIM_W)) u_delim_sel (
        .pat   (delim_pat),
        .idx   (r_q.idx[DCW-1:0]),
        .bit_o (delim_bit)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            PS_IDLE: begin
                if (start) begin
                    if (sync_reps != '0) begin
                        r_d.st  = PS_SYNC;
                        r_d.idx = IDX_W'(sync_top);
                        r_d.rep = sync_reps - REP_W'(1);
                    end else begin
                        r_d.st  = PS_DELIM;
                        r_d.idx = IDX_W'(delim_top);
                    end
                end
            end
            PS_SYNC: begin
                if (bit_en) begin
                    if (r_q.idx == '0) begin
                        if (r_q.rep == '0) begin
                            r_d.st  = PS_DELIM;
                            r_d.idx = IDX_W'(delim_top);
                        end else begin
                            r_d.rep = r_q.rep - REP_W'(1);
                            r_d.idx = IDX_W'(sync_top);
                        end
                    end else begin
                        r_d.idx = r_q.idx - IDX_W'(1);
                    end
                end
            end
            PS_DELIM: begin
                if (bit_en) begin
                    if (r_q.idx == '0) begin
                        r_d.st = PS_FIN;
                    end else begin
                        r_d.idx = r_q.idx - IDX_W'(1);
                    end
                end
            end
            PS_FIN: begin
                if (bit_en) begin
                    r_d.st = PS_IDLE;
                end
            end
            default: r_d.st = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st  <= PS_IDLE;
            r_q.idx <= '0;
            r_q.rep <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        ser_vld = (r_q.st == PS_SYNC) || (r_q.st == PS_DELIM);
        done    = (r_q.st == PS_FIN);
        unique case (r_q.st)
            PS_SYNC:  ser_bit = sync_bit;
            PS_DELIM: ser_bit = delim_bit;
            default:  ser_bit = 1'b0;
        endcase
    end

    // R1 / R10: reset forces idle outputs
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!ser_vld && !done && !ser_bit));

    // R2: sync bit index stays within the decoded sync length
    assert_sync_idx_R2: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == PS_SYNC) |-> (r_q.idx <= IDX_W'(sync_top)));

    // R3: remaining repeat count stays below the programmed count
    assert_rep_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == PS_SYNC) |-> (r_q.rep < sync_reps));

    // R4: delimiter bit index stays within the decoded delimiter length
    assert_delim_idx_R4: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == PS_DELIM) |-> (r_q.idx <= IDX_W'(delim_top)));

    // R6: no movement without a bit enable
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (ser_vld && !bit_en) |=> ($stable(ser_bit) && ser_vld));

    // R7: last delimiter bit leads into done
    assert_last_done_R7: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == PS_DELIM && r_q.idx == '0 && bit_en) |=> (done && !ser_vld));

    // R7: done holds until the next enable, then drops to idle
    assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !bit_en) |=> done);
    assert_done_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (done && bit_en) |=> (!done && !ser_vld));

    // R9: start from idle puts a bit on the line one cycle later
    assert_start_R9: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == PS_IDLE && start) |=> ser_vld);

endmodule

// File: tb/preamble_gen_test.sv
`timescale 1ns/1ps
module preamble_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        bit_en = 1'b0;
    logic [7:0]  sync_pat = '0;
    logic [2:0]  sync_len_code = '0;
    logic [7:0]  sync_reps = '0;
    logic [31:0] delim_pat = '0;
    logic [4:0]  delim_len_code = '0;
    logic        ser_bit, ser_vld, done;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    preamble_gen uut (
        .clk            (clk),
        .rst            (rst),
        .start          (start),
        .bit_en         (bit_en),
        .sync_pat       (sync_pat),
        .sync_len_code  (sync_len_code),
        .sync_reps      (sync_reps),
        .delim_pat      (delim_pat),
        .delim_len_code (delim_len_code),
        .ser_bit        (ser_bit),
        .ser_vld        (ser_vld),
        .done           (done)
    );

    typedef struct packed {
        logic [7:0]  sp;
        logic [2:0]  sc;
        logic [7:0]  rp;
        logic [31:0] dp;
        logic [4:0]  dc;
        logic [3:0]  gap;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'hA5, 3'd7, 8'd3,   32'hDEADBEEF, 5'd31, 4'd1},
        '{8'h03, 3'd1, 8'd1,   32'h00000005, 5'd2,  4'd3},
        '{8'hFE, 3'd0, 8'd2,   32'hFFFFFFF1, 5'd0,  4'd2},
        '{8'h00, 3'd3, 8'd0,   32'h00000ACE, 5'd11, 4'd1},
        '{8'h15, 3'd4, 8'd255, 32'h00001234, 5'd15, 4'd1},
        '{8'h6C, 3'd5, 8'd4,   32'h000A5A5A, 5'd19, 4'd2}
    };

    logic exp_bits [0:2111];
    int   exp_n;
    int   exp_ns;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic build_exp(input vec_t v);
        int slen, dlen;
        slen = (v.sc == 0) ? 2 : int'(v.sc) + 1;
        dlen = (v.dc == 0) ? 2 : int'(v.dc) + 1;
        exp_n = 0;
        for (int r = 0; r < int'(v.rp); r++) begin
            for (int i = slen - 1; i >= 0; i--) begin
                exp_bits[exp_n] = v.sp[i];
                exp_n++;
            end
        end
        exp_ns = exp_n;
        for (int i = dlen - 1; i >= 0; i--) begin
            exp_bits[exp_n] = v.dp[i];
            exp_n++;
        end
    endtask

    task automatic run_vec(input vec_t v, input string tag, input bit poke);
        int  cap, done_cnt, mism, mism_act, cyc, gap;
        bit  fin, overlap, en;
        string t;
        build_exp(v);
        gap = int'(v.gap);
        @(negedge clk);
        sync_pat = v.sp; sync_len_code = v.sc; sync_reps = v.rp;
        delim_pat = v.dp; delim_len_code = v.dc;
        start = 1'b1; bit_en = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(ser_vld == 1'b1, "R9 first bit after start", int'(ser_vld), 1);
        cap = 0; done_cnt = 0; mism = -1; mism_act = 0; cyc = 0;
        fin = 1'b0; overlap = 1'b0;
        while (!fin && cyc < 20000) begin
            en = ((cyc % gap) == gap - 1);
            start = (poke && cyc == 3);
            if (done) begin
                done_cnt++;
                if (ser_vld) overlap = 1'b1;
                if (en) fin = 1'b1;
            end else if (ser_vld && en) begin
                if (cap < exp_n && mism < 0 && ser_bit != exp_bits[cap]) begin
                    mism = cap;
                    mism_act = int'(ser_bit);
                end
                cap++;
            end
            bit_en = en;
            @(negedge clk);
            cyc++;
        end
        bit_en = 1'b0;
        start  = 1'b0;
        chk(!done && !ser_vld, "R7 idle after done", int'({done, ser_vld}), 0);
        chk(cap == exp_n, "R3 total preamble bits", cap, exp_n);
        if (tag != "") t = tag;
        else if (mism >= 0 && mism < exp_ns) t = "R2 sync bit order";
        else t = "R4 delimiter bit order";
        chk(mism < 0, t, mism_act, (mism >= 0) ? int'(exp_bits[mism]) : mism_act);
        chk(done_cnt == gap, "R7 done length", done_cnt, gap);
        chk(!overlap, "R7 done without valid", int'(overlap), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!ser_vld && !done && !ser_bit, "R1 reset outputs", int'({ser_vld, done, ser_bit}), 0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            run_vec(VECS[k], (VECS[k].sc == 0) ? "R5 code zero length" : "", 1'b0);
        end

        // R8: start pulsed mid-frame must not disturb the frame
        run_vec(VECS[1], "R8 start while busy", 1'b1);

        // R6: hold while bit_en low (pattern A5, first bit 1, second 0)
        @(negedge clk);
        sync_pat = 8'hA5; sync_len_code = 3'd7; sync_reps = 8'd2;
        delim_pat = 32'h3; delim_len_code = 5'd1;
        start = 1'b1; bit_en = 1'b0;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
        end
        chk(ser_vld && ser_bit == 1'b1, "R6 hold without enable", int'({ser_vld, ser_bit}), 3);
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        chk(ser_vld && ser_bit == 1'b0, "R6 advance on enable", int'({ser_vld, ser_bit}), 2);

        // R10: reset mid-frame aborts, then stays idle under enables
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!ser_vld && !done, "R10 abort on reset", int'({ser_vld, done}), 0);
        bit_en = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
        end
        bit_en = 1'b0;
        chk(!ser_vld && !done && !ser_bit, "R10 idle without start", int'({ser_vld, done, ser_bit}), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule